// File: doc/BRIEF.md
# Raster Slot and Line Timing Generator

This block drives the raster timing of a tile-based display engine. A master-clock cycle counter divides time into access slots. A horizontal slot counter steps through each scan line, and a vertical line counter steps through each frame. Three timings can be selected: a wide 40-cell timing, a narrow 32-cell timing, and a legacy compatibility timing. The legacy timing follows the narrow slot sequence but changes line at a later slot.

In wide timing the slot counter skips a range of values, and a group of slots near the sync period each have their own length, taken from a computed table. The vertical counter does not step when the slot counter wraps. It steps at a mode-specific slot in the middle of the line. The vertical-blank flag and the vertical interrupt are evaluated a fixed number of slots after that step. The renderer, the sprite fetcher and the DMA engine sample these counters and strobes, and they raise no request back to the block.

Top module: `scan_timing_gen`

## Requirements
- R1: In wide timing (wide_mode=1, legacy_mode=0) the slot after 182 is 229. Every other slot change, in every timing, adds one modulo 256, so slot 255 is followed by slot 0.
- R2: In wide timing a slot outside the sync window lasts SLOT_LEN_WIDE master clocks. In narrow and legacy timing every slot lasts SLOT_LEN_NARROW master clocks.
- R3: In wide timing, slots HSYNC_FIRST up to HSYNC_FIRST+HSYNC_SLOTS-1 take their length from a table indexed by slot minus HSYNC_FIRST. An even index lasts SYNC_LEN_EVEN clocks and an odd index lasts SYNC_LEN_ODD clocks.
- R4: vcounter increments in the same clock that hslot takes the line-change slot, which is 165 in wide timing and 133 in narrow timing. line_change is high for exactly that one clock.
- R5: With legacy_mode=1 the block uses the narrow slot sequence and slot length, whatever wide_mode is, and the line-change slot is 249.
- R6: vblank is updated only in the clock where hslot takes the line-change slot plus 2. It becomes 1 when vcounter is at least ACTIVE_LINES and 0 otherwise, and it holds its value at all other times.
- R7: hblank is 1 exactly while hslot is at least the blank-start slot, which is HBLANK_WIDE in wide timing and 233 in narrow and legacy timing. hblank is 0 at slot 0.
- R8: With vint_en=1, vint_irq pulses for one clock when hslot takes the line-change slot plus 2 on line ACTIVE_LINES (wide and narrow) or on line ACTIVE_LINES+1 (legacy), once per frame.
- R9: At the line change of line LINES_TOTAL-1, vcounter returns to 0 and frame_start pulses together with line_change. vcounter never reaches LINES_TOTAL.
- R10: While rst is high, hslot, vcounter and the internal cycle count are 0, and all flags and pulses are 0.
- R11: With vint_en=0, vint_irq stays 0 for a whole frame, including at the slot where it would otherwise fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| wide_mode | input | 1 | 1 selects the 40-cell timing |
| legacy_mode | input | 1 | 1 selects the legacy timing; takes priority over wide_mode |
| vint_en | input | 1 | Enables the vertical interrupt pulse |
| hslot | output | HSLOT_W | Horizontal slot counter |
| vcounter | output | VCNT_W | Vertical line counter |
| hblank | output | 1 | Horizontal blank flag |
| vblank | output | 1 | Vertical blank flag |
| line_change | output | 1 | One-clock pulse when vcounter steps |
| frame_start | output | 1 | One-clock pulse when vcounter wraps to 0 |
| vint_irq | output | 1 | One-clock vertical interrupt pulse |

## Verification
The bench keeps every slot number at its default: the jump points, the line-change slots, the blank starts and the sync-window position. It shrinks the time-related parameters. Slots last 2 clocks (wide) or 3 clocks (narrow and legacy), and sync-window slots last 3 or 4 clocks, so even and odd table entries can be told apart. A frame has 12 lines, 8 of them active. With these values, whole frames in all three timings can be run directly, including the vertical wrap, the blank edges on both sides, and the one-line delay of the legacy interrupt.

// File: rtl/stg_pkg.sv
package stg_pkg;

   // Timing variant actually in force after decoding the mode pins.
   typedef enum logic [1:0] {
      TM_NARROW = 2'd0,
      TM_WIDE   = 2'd1,
      TM_LEGACY = 2'd2
   } tmode_e;

   // Legacy timing wins over the wide/narrow select.
   function automatic tmode_e pick_mode(input logic wide, input logic legacy);
      if (legacy) return TM_LEGACY;
      if (wide)   return TM_WIDE;
      return TM_NARROW;
   endfunction

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/stg_slot_len.sv
// Length (in master clocks) of the slot currently being served.
module stg_slot_len
   import stg_pkg::*;
#(
   parameter int unsigned HSLOT_W         = 8,
   parameter int unsigned CYC_W           = 5,
   parameter int unsigned SLOT_LEN_WIDE   = 8,
   parameter int unsigned SLOT_LEN_NARROW = 10,
   parameter int unsigned HSYNC_FIRST     = 230,
   parameter int unsigned HSYNC_SLOTS     = 17,
   parameter int unsigned SYNC_LEN_EVEN   = 19,
   parameter int unsigned SYNC_LEN_ODD    = 20
) (
   input  tmode_e              mode,
   input  logic [HSLOT_W-1:0]  hslot,
   output logic [CYC_W-1:0]    slot_len
);

   localparam logic [CYC_W-1:0] LEN_W = SLOT_LEN_WIDE[CYC_W-1:0];
   localparam logic [CYC_W-1:0] LEN_N = SLOT_LEN_NARROW[CYC_W-1:0];

   logic [CYC_W-1:0] wide_len;

   generate
      if (HSYNC_SLOTS > 0) begin : g_sync_rom
         localparam int unsigned IDX_W = (HSYNC_SLOTS > 1) ? $clog2(HSYNC_SLOTS) : 1;
         localparam logic [HSLOT_W-1:0] WIN_BASE = HSYNC_FIRST[HSLOT_W-1:0];
         localparam logic [HSLOT_W:0]   WIN_CNT  = HSYNC_SLOTS[HSLOT_W:0];

         logic [CYC_W-1:0]   rom [HSYNC_SLOTS];
         logic [HSLOT_W-1:0] off;
         logic               in_win;

         // Constant table, one entry per sync-window slot.
         for (genvar i = 0; i < HSYNC_SLOTS; i++) begin : g_entry
            if ((i % 2) == 0) begin : g_even
               assign rom[i] = SYNC_LEN_EVEN[CYC_W-1:0];
            end else begin : g_odd
               assign rom[i] = SYNC_LEN_ODD[CYC_W-1:0];
            end
         end

         assign off    = hslot - WIN_BASE;
         assign in_win = ({1'b0, off} < WIN_CNT);

         always_comb begin
            wide_len = LEN_W;
            if (in_win) wide_len = rom[off[IDX_W-1:0]];
         end
      end else begin : g_no_sync
         assign wide_len = LEN_W;
      end
   endgenerate

   always_comb begin
      unique case (mode)
         TM_WIDE: slot_len = wide_len;
         default: slot_len = LEN_N;
      endcase
   end

endmodule

// File: rtl/stg_cycle_timer.sv
// Counts master clocks inside the slot; fires slot_adv on the last one.
module stg_cycle_timer #(
   parameter int unsigned CYC_W = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CYC_W-1:0] slot_len,
   output logic             slot_adv
);

   logic [CYC_W-1:0] cyc;
   logic [CYC_W-1:0] last_cyc;

   assign last_cyc = slot_len - 1'b1;
   // ">=" keeps the timer from running away if the length shrinks mid-slot.
   assign slot_adv = (cyc >= last_cyc);

   always_ff @(posedge clk) begin
      if (rst) begin
         cyc <= '0;
      end else if (slot_adv) begin
         cyc <= '0;
      end else begin
         cyc <= cyc + 1'b1;
      end
   end

endmodule

// File: rtl/stg_hcount.sv
// Horizontal slot counter with optional skip and blank flag.
module stg_hcount
   import stg_pkg::*;
#(
   parameter int unsigned HSLOT_W       = 8,
   parameter int unsigned JUMP_FROM     = 182,
   parameter int unsigned JUMP_TO       = 229,
   parameter int unsigned HBLANK_WIDE   = 178,
   parameter int unsigned HBLANK_NARROW = 233
) (
   input  logic               clk,
   input  logic               rst,
   input  tmode_e             mode,
   input  logic               slot_adv,
   output logic [HSLOT_W-1:0] hslot,
   output logic [HSLOT_W-1:0] hslot_nxt,
   output logic               hblank
);

   localparam logic [HSLOT_W-1:0] HB_W = HBLANK_WIDE[HSLOT_W-1:0];
   localparam logic [HSLOT_W-1:0] HB_N = HBLANK_NARROW[HSLOT_W-1:0];

   logic [HSLOT_W-1:0] hb_first;
   logic [HSLOT_W-1:0] linear_nxt;

   assign linear_nxt = hslot + 1'b1;

   generate
      if (JUMP_TO == JUMP_FROM + 1) begin : g_linear
         assign hslot_nxt = linear_nxt;
      end else begin : g_skip
         localparam logic [HSLOT_W-1:0] J_FROM = JUMP_FROM[HSLOT_W-1:0];
         localparam logic [HSLOT_W-1:0] J_TO   = JUMP_TO[HSLOT_W-1:0];
         always_comb begin
            hslot_nxt = linear_nxt;
            if ((mode == TM_WIDE) && (hslot == J_FROM)) hslot_nxt = J_TO;
         end
      end
   endgenerate

   assign hb_first = (mode == TM_WIDE) ? HB_W : HB_N;

   always_ff @(posedge clk) begin
      if (rst) begin
         hslot  <= '0;
         hblank <= 1'b0;
      end else if (slot_adv) begin
         hslot  <= hslot_nxt;
         hblank <= (hslot_nxt >= hb_first);
      end
   end

endmodule

// File: rtl/stg_vcount.sv
// Vertical line counter, vertical blank, frame and interrupt strobes.
module stg_vcount
   import stg_pkg::*;
#(
   parameter int unsigned HSLOT_W      = 8,
   parameter int unsigned VCNT_W       = 9,
   parameter int unsigned LC_WIDE      = 165,
   parameter int unsigned LC_NARROW    = 133,
   parameter int unsigned LC_LEGACY    = 249,
   parameter int unsigned VB_OFFSET    = 2,
   parameter int unsigned LINES_TOTAL  = 262,
   parameter int unsigned ACTIVE_LINES = 224
) (
   input  logic               clk,
   input  logic               rst,
   input  tmode_e             mode,
   input  logic               vint_en,
   input  logic               slot_adv,
   input  logic [HSLOT_W-1:0] hslot_nxt,
   output logic [VCNT_W-1:0]  vcounter,
   output logic               vblank,
   output logic               line_change,
   output logic               frame_start,
   output logic               vint_irq
);

   localparam logic [HSLOT_W-1:0] LCW   = LC_WIDE[HSLOT_W-1:0];
   localparam logic [HSLOT_W-1:0] LCN   = LC_NARROW[HSLOT_W-1:0];
   localparam logic [HSLOT_W-1:0] LCL   = LC_LEGACY[HSLOT_W-1:0];
   localparam logic [HSLOT_W-1:0] VBW   = LCW + VB_OFFSET[HSLOT_W-1:0];
   localparam logic [HSLOT_W-1:0] VBN   = LCN + VB_OFFSET[HSLOT_W-1:0];
   localparam logic [HSLOT_W-1:0] VBL   = LCL + VB_OFFSET[HSLOT_W-1:0];
   localparam logic [VCNT_W-1:0]  V_LST = VCNT_W'(LINES_TOTAL - 1);
   localparam logic [VCNT_W-1:0]  V_ACT = VCNT_W'(ACTIVE_LINES);
   localparam logic [VCNT_W-1:0]  V_INT_NAT = VCNT_W'(ACTIVE_LINES);
   localparam logic [VCNT_W-1:0]  V_INT_LEG = VCNT_W'(ACTIVE_LINES + 1);

   logic [HSLOT_W-1:0] lc_slot;
   logic [HSLOT_W-1:0] vb_slot;
   logic [VCNT_W-1:0]  vint_line;
   logic               at_lc;
   logic               at_vb;

   always_comb begin
      unique case (mode)
         TM_WIDE: begin
            lc_slot   = LCW;
            vb_slot   = VBW;
            vint_line = V_INT_NAT;
         end
         TM_LEGACY: begin
            lc_slot   = LCL;
            vb_slot   = VBL;
            vint_line = V_INT_LEG;
         end
         default: begin
            lc_slot   = LCN;
            vb_slot   = VBN;
            vint_line = V_INT_NAT;
         end
      endcase
   end

   assign at_lc = slot_adv && (hslot_nxt == lc_slot);
   assign at_vb = slot_adv && (hslot_nxt == vb_slot);

   always_ff @(posedge clk) begin
      if (rst) begin
         vcounter    <= '0;
         vblank      <= 1'b0;
         line_change <= 1'b0;
         frame_start <= 1'b0;
         vint_irq    <= 1'b0;
      end else begin
         line_change <= at_lc;
         frame_start <= at_lc && (vcounter == V_LST);
         vint_irq    <= 1'b0;
         if (at_lc) begin
            vcounter <= (vcounter == V_LST) ? '0 : vcounter + 1'b1;
         end
         // The line counter has already stepped by the time the offset slot arrives.
         if (at_vb) begin
            vblank   <= (vcounter >= V_ACT);
            vint_irq <= vint_en && (vcounter == vint_line);
         end
      end
   end

endmodule

// File: rtl/scan_timing_gen.sv
module scan_timing_gen
   import stg_pkg::*;
#(
   parameter int unsigned HSLOT_W         = 8,
   parameter int unsigned VCNT_W          = 9,
   parameter int unsigned SLOT_LEN_WIDE   = 8,
   parameter int unsigned SLOT_LEN_NARROW = 10,
   parameter int unsigned SYNC_LEN_EVEN   = 19,
   parameter int unsigned SYNC_LEN_ODD    = 20,
   parameter int unsigned HSYNC_FIRST     = 230,
   parameter int unsigned HSYNC_SLOTS     = 17,
   parameter int unsigned JUMP_FROM       = 182,
   parameter int unsigned JUMP_TO         = 229,
   parameter int unsigned LC_WIDE         = 165,
   parameter int unsigned LC_NARROW       = 133,
   parameter int unsigned LC_LEGACY       = 249,
   parameter int unsigned VB_OFFSET       = 2,
   parameter int unsigned HBLANK_WIDE     = 178,
   parameter int unsigned HBLANK_NARROW   = 233,
   parameter int unsigned LINES_TOTAL     = 262,
   parameter int unsigned ACTIVE_LINES    = 224
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               wide_mode,
   input  logic               legacy_mode,
   input  logic               vint_en,
   output logic [HSLOT_W-1:0] hslot,
   output logic [VCNT_W-1:0]  vcounter,
   output logic               hblank,
   output logic               vblank,
   output logic               line_change,
   output logic               frame_start,
   output logic               vint_irq
);

   localparam int unsigned MAX_LEN = umax(umax(SLOT_LEN_WIDE, SLOT_LEN_NARROW),
                                          umax(SYNC_LEN_EVEN, SYNC_LEN_ODD));
   localparam int unsigned CYC_W   = $clog2(MAX_LEN + 1);
   localparam int unsigned HSPAN   = 1 << HSLOT_W;

   // Elaboration-time parameter checks.
   generate
      if (SLOT_LEN_WIDE < 1 || SLOT_LEN_NARROW < 1 || SYNC_LEN_EVEN < 1 || SYNC_LEN_ODD < 1) begin : g_bad_len
         $error("slot lengths must be at least one clock");
      end
      if (JUMP_FROM >= JUMP_TO || JUMP_TO >= HSPAN) begin : g_bad_jump
         $error("slot skip must go forward inside the counter range");
      end
      if (HSYNC_SLOTS > 0 && (HSYNC_FIRST < JUMP_TO || HSYNC_FIRST + HSYNC_SLOTS > HSPAN)) begin : g_bad_sync
         $error("sync window must lie in the post-skip slot range");
      end
      if (LC_WIDE + VB_OFFSET >= HSPAN || LC_NARROW + VB_OFFSET >= HSPAN || LC_LEGACY + VB_OFFSET >= HSPAN) begin : g_bad_lc
         $error("line change slot plus blank offset exceeds slot range");
      end
      if (VB_OFFSET == 0) begin : g_bad_vbo
         $error("blank offset must be non-zero");
      end
      if (ACTIVE_LINES + 1 >= LINES_TOTAL || LINES_TOTAL > (1 << VCNT_W)) begin : g_bad_lines
         $error("line counts do not fit the vertical counter");
      end
   endgenerate

   tmode_e             mode;
   logic [CYC_W-1:0]   slot_len;
   logic               slot_adv;
   logic [HSLOT_W-1:0] hslot_nxt;

   assign mode = pick_mode(wide_mode, legacy_mode);

   stg_slot_len #(
      .HSLOT_W        (HSLOT_W),
      .CYC_W          (CYC_W),
      .SLOT_LEN_WIDE  (SLOT_LEN_WIDE),
      .SLOT_LEN_NARROW(SLOT_LEN_NARROW),
      .HSYNC_FIRST    (HSYNC_FIRST),
      .HSYNC_SLOTS    (HSYNC_SLOTS),
      .SYNC_LEN_EVEN  (SYNC_LEN_EVEN),
      .SYNC_LEN_ODD   (SYNC_LEN_ODD)
   ) u_len (
      .mode    (mode),
      .hslot   (hslot),
      .slot_len(slot_len)
   );

   stg_cycle_timer #(
      .CYC_W(CYC_W)
   ) u_timer (
      .clk     (clk),
      .rst     (rst),
      .slot_len(slot_len),
      .slot_adv(slot_adv)
   );

   stg_hcount #(
      .HSLOT_W      (HSLOT_W),
      .JUMP_FROM    (JUMP_FROM),
      .JUMP_TO      (JUMP_TO),
      .HBLANK_WIDE  (HBLANK_WIDE),
      .HBLANK_NARROW(HBLANK_NARROW)
   ) u_h (
      .clk      (clk),
      .rst      (rst),
      .mode     (mode),
      .slot_adv (slot_adv),
      .hslot    (hslot),
      .hslot_nxt(hslot_nxt),
      .hblank   (hblank)
   );

   stg_vcount #(
      .HSLOT_W     (HSLOT_W),
      .VCNT_W      (VCNT_W),
      .LC_WIDE     (LC_WIDE),
      .LC_NARROW   (LC_NARROW),
      .LC_LEGACY   (LC_LEGACY),
      .VB_OFFSET   (VB_OFFSET),
      .LINES_TOTAL (LINES_TOTAL),
      .ACTIVE_LINES(ACTIVE_LINES)
   ) u_v (
      .clk        (clk),
      .rst        (rst),
      .mode       (mode),
      .vint_en    (vint_en),
      .slot_adv   (slot_adv),
      .hslot_nxt  (hslot_nxt),
      .vcounter   (vcounter),
      .vblank     (vblank),
      .line_change(line_change),
      .frame_start(frame_start),
      .vint_irq   (vint_irq)
   );

endmodule

// File: rtl/stg_checker.sv
module stg_checker #(
   parameter int unsigned HSLOT_W     = 8,
   parameter int unsigned VCNT_W      = 9,
   parameter int unsigned JUMP_FROM   = 182,
   parameter int unsigned JUMP_TO     = 229,
   parameter int unsigned LC_WIDE     = 165,
   parameter int unsigned LC_NARROW   = 133,
   parameter int unsigned LC_LEGACY   = 249,
   parameter int unsigned LINES_TOTAL = 262
) (
   input logic               clk,
   input logic               rst,
   input logic               wide_mode,
   input logic               legacy_mode,
   input logic               vint_en,
   input logic               slot_adv,
   input logic [HSLOT_W-1:0] hslot,
   input logic [VCNT_W-1:0]  vcounter,
   input logic               hblank,
   input logic               vblank,
   input logic               line_change,
   input logic               frame_start,
   input logic               vint_irq
);

   localparam logic [HSLOT_W-1:0] J_FROM = JUMP_FROM[HSLOT_W-1:0];
   localparam logic [HSLOT_W-1:0] J_TO   = JUMP_TO[HSLOT_W-1:0];
   localparam logic [HSLOT_W-1:0] LCW    = LC_WIDE[HSLOT_W-1:0];
   localparam logic [HSLOT_W-1:0] LCN    = LC_NARROW[HSLOT_W-1:0];
   localparam logic [HSLOT_W-1:0] LCL    = LC_LEGACY[HSLOT_W-1:0];
   localparam logic [VCNT_W-1:0]  V_LST  = VCNT_W'(LINES_TOTAL - 1);
   localparam logic [VCNT_W:0]    V_TOT  = (VCNT_W+1)'(LINES_TOTAL);

   AST_WIDE_SKIP: assert property (@(posedge clk) disable iff (rst)
      (slot_adv && wide_mode && !legacy_mode && hslot == J_FROM) |=> (hslot == J_TO)); // R1

   AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (rst)
      !slot_adv |=> $stable(hslot)); // R2

   AST_LINE_SLOT: assert property (@(posedge clk) disable iff (rst)
      line_change |-> (hslot == ($past(legacy_mode) ? LCL : ($past(wide_mode) ? LCW : LCN)))); // R4

   AST_LINE_STEP: assert property (@(posedge clk) disable iff (rst)
      (line_change && !frame_start) |-> (vcounter == $past(vcounter) + 1'b1)); // R4

   AST_VBLANK_EDGE: assert property (@(posedge clk) disable iff (rst)
      !$stable(vblank) |-> $past(slot_adv)); // R6

   AST_HBLANK_LOW_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
      (hslot == '0) |-> !hblank); // R7

   AST_VINT_GATED: assert property (@(posedge clk) disable iff (rst)
      vint_irq |-> ($past(vint_en) && vblank)); // R11

   AST_VINT_SINGLE: assert property (@(posedge clk) disable iff (rst)
      vint_irq |=> !vint_irq); // R8

   AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (rst)
      frame_start |-> (vcounter == '0 && line_change && $past(vcounter) == V_LST)); // R9

   AST_VCNT_RANGE: assert property (@(posedge clk) disable iff (rst)
      ({1'b0, vcounter} < V_TOT)); // R9

endmodule

bind scan_timing_gen stg_checker #(
   .HSLOT_W    (HSLOT_W),
   .VCNT_W     (VCNT_W),
   .JUMP_FROM  (JUMP_FROM),
   .JUMP_TO    (JUMP_TO),
   .LC_WIDE    (LC_WIDE),
   .LC_NARROW  (LC_NARROW),
   .LC_LEGACY  (LC_LEGACY),
   .LINES_TOTAL(LINES_TOTAL)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .wide_mode  (wide_mode),
   .legacy_mode(legacy_mode),
   .vint_en    (vint_en),
   .slot_adv   (slot_adv),
   .hslot      (hslot),
   .vcounter   (vcounter),
   .hblank     (hblank),
   .vblank     (vblank),
   .line_change(line_change),
   .frame_start(frame_start),
   .vint_irq   (vint_irq)
);

// File: tb/scan_timing_gen_bench.sv
`timescale 1ns/1ps
module scan_timing_gen_bench;

   localparam int SLW    = 2;
   localparam int SLN    = 3;
   localparam int SEVEN  = 3;
   localparam int SODD   = 4;
   localparam int LINES  = 12;
   localparam int ACTIVE = 8;
   localparam int HBW    = 178;
   localparam int HBN    = 233;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       wide_mode = 1'b1;
   logic       legacy_mode = 1'b0;
   logic       vint_en = 1'b1;
   logic [7:0] hslot;
   logic [8:0] vcounter;
   logic       hblank, vblank, line_change, frame_start, vint_irq;

   int n_chk = 0;
   int n_bad = 0;
   int clk_cnt = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   scan_timing_gen #(
      .SLOT_LEN_WIDE  (SLW),
      .SLOT_LEN_NARROW(SLN),
      .SYNC_LEN_EVEN  (SEVEN),
      .SYNC_LEN_ODD   (SODD),
      .LINES_TOTAL    (LINES),
      .ACTIVE_LINES   (ACTIVE),
      .HBLANK_WIDE    (HBW)
   ) u_scan_timing_gen (
      .clk        (clk),
      .rst        (rst),
      .wide_mode  (wide_mode),
      .legacy_mode(legacy_mode),
      .vint_en    (vint_en),
      .hslot      (hslot),
      .vcounter   (vcounter),
      .hblank     (hblank),
      .vblank     (vblank),
      .line_change(line_change),
      .frame_start(frame_start),
      .vint_irq   (vint_irq)
   );

   task automatic report;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      clk_cnt++;
      if (clk_cnt > 190000 && !finished) begin
         finished = 1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected completion", clk_cnt);
         report();
      end
   end

   task automatic check(input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic do_reset(input logic w, input logic l, input logic e);
      @(negedge clk);
      rst = 1'b1;
      wide_mode = w;
      legacy_mode = l;
      vint_en = e;
      repeat (3) @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic wait_slot(input int s);
      while (hslot != s) @(negedge clk);
   endtask

   // Number of clocks hslot stays at s; returns on the first clock of the next slot.
   task automatic dwell(input int s, output int n);
      wait_slot(s);
      n = 0;
      while (hslot == s) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic t_reset;
      @(negedge clk);
      rst = 1'b1;
      wide_mode = 1'b1;
      legacy_mode = 1'b0;
      repeat (5) @(negedge clk);
      check("R10", "state under reset", int'({hslot, vcounter, hblank, vblank, line_change, frame_start, vint_irq}), 0);
      rst = 1'b0;
      @(negedge clk);
      check("R10", "slot 0 held after reset (cycle count cleared)", int'(hslot), 0);
      @(negedge clk);
      check("R10", "first slot step after reset", int'(hslot), 1);
   endtask

   task automatic t_wide_slots;
      int n;
      int prev;
      int errs;
      do_reset(1'b1, 1'b0, 1'b1);
      dwell(0, n);
      check("R2", "wide slot 0 length", n, SLW);
      prev = hslot;
      errs = 0;
      while (prev != 182) begin
         @(negedge clk);
         if (hslot != prev) begin
            if (hslot != prev + 1) errs++;
            prev = hslot;
         end
      end
      check("R1", "wide increments below skip", errs, 0);
      dwell(182, n);
      check("R2", "wide slot 182 length", n, SLW);
      check("R1", "slot after 182", int'(hslot), 229);
      dwell(229, n);
      check("R2", "wide slot 229 length", n, SLW);
      dwell(230, n);
      check("R3", "sync slot index 0", n, SEVEN);
      dwell(231, n);
      check("R3", "sync slot index 1", n, SODD);
      dwell(246, n);
      check("R3", "sync slot index 16", n, SEVEN);
      dwell(247, n);
      check("R3", "first slot past sync window", n, SLW);
      dwell(255, n);
      check("R1", "wide wrap 255 to 0", int'(hslot), 0);
   endtask

   task automatic t_narrow_slots;
      int n;
      do_reset(1'b0, 1'b0, 1'b1);
      dwell(5, n);
      check("R2", "narrow slot length", n, SLN);
      dwell(182, n);
      check("R1", "narrow slot after 182", int'(hslot), 183);
      dwell(240, n);
      check("R2", "narrow late slot length", n, SLN);
      dwell(255, n);
      check("R1", "narrow wrap 255 to 0", int'(hslot), 0);
   endtask

   task automatic t_legacy_slots;
      int n;
      do_reset(1'b1, 1'b1, 1'b1);
      dwell(10, n);
      check("R5", "legacy slot length with wide_mode high", n, SLN);
      dwell(182, n);
      check("R5", "legacy no skip at 182", int'(hslot), 183);
      dwell(231, n);
      check("R5", "legacy sync-range slot length", n, SLN);
   endtask

   task automatic t_line(input logic w, input logic l, input int lc, input string tag);
      int n;
      do_reset(w, l, 1'b1);
      wait_slot(lc - 1);
      check(tag, "no line change before slot", int'({vcounter, line_change}), 0);
      dwell(lc - 1, n);
      check(tag, "hslot at line change", int'(hslot), lc);
      check(tag, "line_change pulse", int'(line_change), 1);
      check(tag, "vcounter stepped", int'(vcounter), 1);
      @(negedge clk);
      check(tag, "line_change one clock", int'(line_change), 0);
   endtask

   task automatic t_hblank(input logic w, input logic l, input int hb, input string what);
      int errs;
      bit left_zero;
      do_reset(w, l, 1'b1);
      errs = 0;
      left_zero = 0;
      while (!(left_zero && hslot == 0)) begin
         if (hblank != (hslot >= hb)) errs++;
         if (hslot != 0) left_zero = 1;
         @(negedge clk);
      end
      check("R7", what, errs, 0);
      check("R7", "hblank low at slot 0", int'(hblank), 0);
   endtask

   task automatic t_frame(input logic w, input logic l, input logic e, input int lc, input string what);
      int vint_n, vint_line, vint_slot, vmax, prev_v;
      bit seen_fs, c1, c2, c3, done;
      do_reset(w, l, e);
      vint_n = 0; vint_line = -1; vint_slot = -1; vmax = 0; prev_v = 0;
      seen_fs = 0; c1 = 0; c2 = 0; c3 = 0; done = 0;
      while (!done) begin
         if (vint_irq) begin
            vint_n++;
            vint_line = vcounter;
            vint_slot = hslot;
         end
         if (vcounter > vmax) vmax = vcounter;
         if (frame_start && !seen_fs) begin
            seen_fs = 1;
            check("R9", {what, " wrap value and line pulse"}, int'({vcounter, line_change}), 1);
            check("R9", {what, " line before wrap"}, prev_v, LINES - 1);
         end
         if (!seen_fs && vcounter == ACTIVE && hslot == lc + 1 && !c1) begin
            c1 = 1;
            check("R6", {what, " vblank low one slot early"}, int'(vblank), 0);
         end
         if (!seen_fs && vcounter == ACTIVE && hslot == lc + 2 && !c2) begin
            c2 = 1;
            check("R6", {what, " vblank rises"}, int'(vblank), 1);
         end
         if (seen_fs && vcounter == 0 && hslot == lc + 1 && !c3) begin
            c3 = 1;
            check("R6", {what, " vblank held into line 0"}, int'(vblank), 1);
         end
         if (seen_fs && vcounter == 0 && hslot == lc + 2) begin
            check("R6", {what, " vblank falls"}, int'(vblank), 0);
            done = 1;
         end
         prev_v = vcounter;
         @(negedge clk);
      end
      check("R9", {what, " highest line"}, vmax, LINES - 1);
      if (e) begin
         check("R8", {what, " vint pulses per frame"}, vint_n, 1);
         check("R8", {what, " vint line"}, vint_line, l ? ACTIVE + 1 : ACTIVE);
         check("R8", {what, " vint slot"}, vint_slot, lc + 2);
      end else begin
         check("R11", {what, " vint with enable low"}, vint_n, 0);
      end
   endtask

   initial begin
      t_reset();
      t_wide_slots();
      t_narrow_slots();
      t_legacy_slots();
      t_line(1'b1, 1'b0, 165, "R4");
      t_line(1'b0, 1'b0, 133, "R4");
      t_line(1'b0, 1'b1, 249, "R5");
      t_hblank(1'b1, 1'b0, HBW, "wide hblank tracks slot");
      t_hblank(1'b0, 1'b0, HBN, "narrow hblank tracks slot");
      t_hblank(1'b0, 1'b1, HBN, "legacy hblank tracks slot");
      t_frame(1'b1, 1'b0, 1'b1, 165, "wide");
      t_frame(1'b0, 1'b0, 1'b1, 133, "narrow");
      t_frame(1'b1, 1'b1, 1'b1, 249, "legacy");
      t_frame(1'b1, 1'b0, 1'b0, 165, "wide masked");
      if (!finished) begin
         finished = 1;
         report();
      end
   end

endmodule